// File: doc/BRIEF.md
# Segmented Data Buffer Transmitter

This block holds a 2 KB transmit memory, split into 128 segments of 16 bytes, and sends a chosen run of it as a framed packet through the data slots of a timing event stream. Software first fills the memory through a byte write port. It then puts a start segment and a transfer size, counted in four-byte units, on the request inputs and pulses the trigger. The framer around the block raises `slot_open` on each cycle that carries a data-buffer slot. The block presents one frame character (an 8-bit value and a K flag) in every open slot and advances by one character per open slot.

A frame has this order: the start comma, the segment index, the payload bytes in rising address order, the end comma, and then a 16-bit checksum sent high byte first. The checksum begins at 0xFFFF. The low byte of the segment's byte address and every payload byte are subtracted from it. The last segment is kept for system data. A request that starts there is refused, and a request that runs into it is cut short at the end of segment 126. Three flags are exposed: transfer in progress, transfer finished, and last request refused.

Top module: `sdbuf_tx`

## Requirements
- R1: After reset, `busy`, `done` and `rejected` are 0 and the character outputs are 0x00 with K flag 0.
- R2: A trigger seen while `busy` is 0 and `start_seg` < 127 starts a transfer. `busy` is 1 and `done` is 0 from the next cycle on.
- R3: The frame characters are sent in this order: K28.2 (0x5C, K=1), the segment index (K=0), the payload bytes from byte address `start_seg`*16 upward (K=0), K28.1 (0x3C, K=1), the checksum high byte, and the checksum low byte (K=0).
- R4: The checksum equals 0xFFFF minus ((`start_seg`*16) mod 256) minus every payload byte, taken modulo 65536. For segment 10 with payload C0 FF EE 99 this gives 0xFC19.
- R5: The frame moves forward by exactly one character on each clock edge where `slot_open` is 1. While `slot_open` is 0, the outputs are 0x00 with K=0.
- R6: An open slot while no transfer runs carries 0x00 with K=0 (the null data character).
- R7: The payload length is `size_units`*4 bytes. A size of 0 gives a frame with no payload.
- R8: A transfer that would run past byte 2031 (the end of segment 126) is cut off after that byte.
- R9: A trigger while idle with `start_seg` = 127 sends nothing, leaves `busy` at 0 and sets `rejected`. The next trigger taken while idle clears `rejected` if that trigger is valid.
- R10: A trigger while `busy` is 1 has no effect on the frame in progress or on the flags.
- R11: The edge that sends the checksum low byte clears `busy` and sets `done`. The next trigger taken while idle clears `done`.
- R12: A byte written through the write port appears in every transfer started after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Memory byte write strobe |
| wr_addr | input | 11 | Memory byte address |
| wr_data | input | 8 | Memory byte data |
| start_seg | input | 7 | First segment of the request |
| size_units | input | 9 | Request length in four-byte units |
| trigger | input | 1 | Start request pulse |
| slot_open | input | 1 | Current cycle is a data-buffer slot |
| tx_char | output | 8 | Character value for the open slot |
| tx_k | output | 1 | Character is a K-character |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| rejected | output | 1 | Last idle trigger was refused |

## Verification
Two events can fall in the same cycle: a new trigger and the open slot that sends the final checksum byte. In that cycle `busy` is still 1, so the trigger has to be ignored even though the block goes idle at the same edge. The bench waits until one character is left in its model queue and then raises the trigger on exactly that open slot. It expects `busy` to drop, `done` to be set, no second frame to follow, and null characters in the slots after that. It also raises a trigger on the same edge as an open slot while idle, and checks that this slot still carries null and the start comma comes in the next open slot.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SOF, ST_ADDR, ST_DATA, ST_EOF, ST_CSH, ST_CSL
  } sdb_state_e;

  localparam logic [7:0] CH_NULL = 8'h00;
  localparam logic [7:0] CH_SOF  = 8'h5C;
  localparam logic [7:0] CH_EOF  = 8'h3C;

  function automatic logic [15:0] csum_sub(input logic [15:0] c, input logic [7:0] b);
    return c - {8'h00, b};
  endfunction
endpackage

// File: rtl/sdb_mem.sv
module sdb_mem #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sdb_csum.sv
module sdb_csum (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  addr_lsb,
  input  logic        step,
  input  logic [7:0]  data,
  output logic [15:0] csum
);
  import sdb_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)    csum <= 16'hFFFF;
    else if (load) csum <= csum_sub(16'hFFFF, addr_lsb);
    else if (step) csum <= csum_sub(csum, data);
  end
endmodule

// File: rtl/sdb_ctrl.sv
module sdb_ctrl #(
  parameter int NUM_SEGS  = 128,
  parameter int SEG_BYTES = 16,
  parameter int SIZE_W    = 9,
  localparam int SEG_W     = $clog2(NUM_SEGS),
  localparam int OFF_W     = $clog2(SEG_BYTES),
  localparam int AW        = SEG_W + OFF_W,
  localparam int LEN_W     = AW + 1,
  localparam int USER_SEGS = NUM_SEGS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [SEG_W-1:0]  start_seg,
  input  logic [SIZE_W-1:0] size_units,
  input  logic              slot_open,
  output sdb_pkg::sdb_state_e state,
  output logic [SEG_W-1:0]  seg_q,
  output logic [AW-1:0]     ptr,
  output logic [7:0]        addr_lsb,
  output logic              accept,
  output logic              data_step,
  output logic              busy,
  output logic              done,
  output logic              rejected
);
  import sdb_pkg::*;

  logic [LEN_W-1:0] rem;
  logic             trig_idle, reject_ev, slot_adv, last_slot;

  function automatic logic [LEN_W-1:0] frame_len(input logic [SEG_W-1:0] s,
                                                 input logic [SIZE_W-1:0] n);
    int unsigned avail, req;
    avail = (USER_SEGS - 32'(s)) * SEG_BYTES;
    req   = 32'(n) * 4;
    return LEN_W'((req < avail) ? req : avail);
  endfunction

  assign busy      = (state != ST_IDLE);
  assign trig_idle = trig && !busy;
  assign accept    = trig_idle && (32'(start_seg) < USER_SEGS);
  assign reject_ev = trig_idle && !(32'(start_seg) < USER_SEGS);
  assign slot_adv  = slot_open && busy;
  assign data_step = slot_adv && (state == ST_DATA);
  assign last_slot = slot_adv && (state == ST_CSL);
  assign addr_lsb  = 8'({start_seg, {OFF_W{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      seg_q    <= '0;
      ptr      <= '0;
      rem      <= '0;
      done     <= 1'b0;
      rejected <= 1'b0;
    end else begin
      if (trig_idle) begin
        done     <= 1'b0;
        rejected <= reject_ev;
      end
      if (accept) begin
        state <= ST_SOF;
        seg_q <= start_seg;
        ptr   <= {start_seg, {OFF_W{1'b0}}};
        rem   <= frame_len(start_seg, size_units);
      end else if (slot_adv) begin
        case (state)
          ST_SOF:  state <= ST_ADDR;
          ST_ADDR: state <= (rem == '0) ? ST_EOF : ST_DATA;
          ST_DATA: begin
            ptr <= ptr + 1'b1;
            rem <= rem - 1'b1;
            if (rem == LEN_W'(1)) state <= ST_EOF;
          end
          ST_EOF:  state <= ST_CSH;
          ST_CSH:  state <= ST_CSL;
          ST_CSL:  begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !done);
  p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> !busy && rejected);
  p_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (32'(ptr) < USER_SEGS * SEG_BYTES));
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy && !last_slot) |=> busy && $stable(seg_q));
  p_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last_slot |=> !busy && done);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

// File: rtl/sdbuf_tx.sv
module sdbuf_tx #(
  parameter int NUM_SEGS  = 128,
  parameter int SEG_BYTES = 16,
  parameter int SIZE_W    = 9,
  localparam int SEG_W = $clog2(NUM_SEGS),
  localparam int AW    = SEG_W + $clog2(SEG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [SEG_W-1:0]  start_seg,
  input  logic [SIZE_W-1:0] size_units,
  input  logic              trigger,
  input  logic              slot_open,
  output logic [7:0]        tx_char,
  output logic              tx_k,
  output logic              busy,
  output logic              done,
  output logic              rejected
);
  import sdb_pkg::*;

  sdb_state_e       state;
  logic [SEG_W-1:0] seg_q;
  logic [AW-1:0]    ptr;
  logic [7:0]       addr_lsb, rd_data;
  logic [15:0]      csum;
  logic             accept, data_step;

  sdb_mem #(.DEPTH(NUM_SEGS * SEG_BYTES)) mem_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data)
  );

  sdb_ctrl #(.NUM_SEGS(NUM_SEGS), .SEG_BYTES(SEG_BYTES), .SIZE_W(SIZE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .trig(trigger), .start_seg(start_seg),
    .size_units(size_units), .slot_open(slot_open), .state(state),
    .seg_q(seg_q), .ptr(ptr), .addr_lsb(addr_lsb), .accept(accept),
    .data_step(data_step), .busy(busy), .done(done), .rejected(rejected)
  );

  sdb_csum csum_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .addr_lsb(addr_lsb),
    .step(data_step), .data(rd_data), .csum(csum)
  );

  always_comb begin
    tx_char = CH_NULL;
    tx_k    = 1'b0;
    if (slot_open) begin
      case (state)
        ST_SOF:  begin tx_char = CH_SOF; tx_k = 1'b1; end
        ST_ADDR: tx_char = 8'(seg_q);
        ST_DATA: tx_char = rd_data;
        ST_EOF:  begin tx_char = CH_EOF; tx_k = 1'b1; end
        ST_CSH:  tx_char = csum[15:8];
        ST_CSL:  tx_char = csum[7:0];
        default: ;
      endcase
    end
  end

  p_closed_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_open |-> (tx_char == 8'h00) && !tx_k);
  p_idle_null_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && slot_open) |-> (tx_char == 8'h00) && !tx_k);
  p_sof_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == ST_SOF));
endmodule

// File: tb/sdbuf_tx_tb_top.sv
`timescale 1ns/1ps
module sdbuf_tx_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, trigger = 0, slot_open = 0;
  logic [10:0] wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [6:0]  start_seg = 0;
  logic [8:0]  size_units = 0;
  logic [7:0]  tx_char;
  logic        tx_k, busy, done, rejected;

  always #2 clk = ~clk;

  sdbuf_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_seg(start_seg), .size_units(size_units), .trigger(trigger),
    .slot_open(slot_open), .tx_char(tx_char), .tx_k(tx_k), .busy(busy),
    .done(done), .rejected(rejected)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] mem_m [2048];
  logic [8:0] q[$];
  logic [8:0] log_q[$];
  bit busy_m = 0, done_m = 0, rej_m = 0;

  // next-cycle stimulus
  bit nxt_slot = 0, nxt_trig = 0, nxt_wr = 0;
  logic [6:0] nxt_seg = 0;
  logic [8:0] nxt_size = 0;
  logic [10:0] nxt_waddr = 0;
  logic [7:0]  nxt_wdata = 0;
  int slot_mode = 0; // 0 alternate, 1 pseudo-random, 2 always
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build_frame(input int seg, input int size);
    int len, avail;
    logic [15:0] c;
    avail = (127 - seg) * 16;
    len = (size * 4 < avail) ? size * 4 : avail;      // R7, R8
    q.delete();
    q.push_back({1'b1, 8'h5C});                        // R3
    q.push_back({1'b0, 8'(seg)});
    c = 16'hFFFF - 16'((seg * 16) % 256);             // R4
    for (int i = 0; i < len; i++) begin
      q.push_back({1'b0, mem_m[seg * 16 + i]});
      c = c - 16'(mem_m[seg * 16 + i]);
    end
    q.push_back({1'b1, 8'h3C});
    q.push_back({1'b0, c[15:8]});
    q.push_back({1'b0, c[7:0]});
  endtask

  task automatic step();
    logic [8:0] exp_c;
    bit trig_now;
    @(negedge clk);
    chk("R2/R11 busy", 32'(busy), 32'(busy_m));
    chk("R11 done", 32'(done), 32'(done_m));
    chk("R9 rejected", 32'(rejected), 32'(rej_m));
    slot_open = nxt_slot; trigger = nxt_trig; start_seg = nxt_seg; size_units = nxt_size;
    wr_en = nxt_wr; wr_addr = nxt_waddr; wr_data = nxt_wdata;
    trig_now = nxt_trig;
    nxt_trig = 0; nxt_wr = 0;
    #1;
    if (!slot_open) exp_c = 9'h000;                    // R5
    else if (busy_m) exp_c = q[0];                     // R3
    else exp_c = 9'h000;                               // R6
    chk(slot_open ? (busy_m ? "R3 frame char" : "R6 idle slot") : "R5 closed slot",
        32'({tx_k, tx_char}), 32'(exp_c));
    // model update for the coming edge
    if (slot_open && busy_m) begin
      log_q.push_back({tx_k, tx_char});
      void'(q.pop_front());
      if (q.size() == 0) begin busy_m = 0; done_m = 1; end
    end else if (trig_now && !busy_m) begin
      done_m = 0;
      if (start_seg == 7'd127) rej_m = 1;              // R9
      else begin rej_m = 0; busy_m = 1; build_frame(int'(start_seg), int'(size_units)); end
    end
    if (wr_en) mem_m[wr_addr] = wr_data;               // R12
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (slot_mode)
      0: nxt_slot = !slot_open;
      1: nxt_slot = lfsr[0];
      default: nxt_slot = 1;
    endcase
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    nxt_wr = 1; nxt_waddr = 11'(a); nxt_wdata = d;
    step();
  endtask

  task automatic trig(input int seg, input int size);
    nxt_trig = 1; nxt_seg = 7'(seg); nxt_size = 9'(size);
    step();
  endtask

  task automatic drain();
    while (busy_m) step();
    repeat (3) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 rejected", 32'(rejected), 0);
    chk("R1 char", 32'({tx_k, tx_char}), 0);

    for (int i = 0; i < 2048; i++) wr(i, 8'((i * 37 + 11) ^ (i >> 3)));
    // R12 overwrite segment 10 with the worked example bytes
    wr(160, 8'hC0); wr(161, 8'hFF); wr(162, 8'hEE); wr(163, 8'h99);
    repeat (2) step();

    // R4 worked example
    log_q.delete();
    trig(10, 1);
    drain();
    chk("R4 example csum msb", 32'(log_q[log_q.size() - 2]), 32'h0FC);
    chk("R4 example csum lsb", 32'(log_q[log_q.size() - 1]), 32'h019);
    chk("R7 example length", 32'(log_q.size()), 9);

    // R3 multi-segment, trigger coinciding with an open idle slot
    while (!nxt_slot) step();
    trig(3, 9);
    drain();

    // R8 clip at segment 126
    log_q.delete();
    trig(125, 20);
    drain();
    chk("R8 clipped length", 32'(log_q.size()), 32 + 5);

    // R7 zero size
    log_q.delete();
    trig(0, 0);
    drain();
    chk("R7 zero payload", 32'(log_q.size()), 5);

    // R9 reject segment 127 then a valid trigger clears it
    trig(127, 2);
    repeat (6) step();
    chk("R9 no frame", 32'(busy), 0);
    trig(126, 4);
    drain();

    // R10 trigger during a transfer
    trig(20, 3);
    repeat (5) step();
    trig(40, 8);
    trig(127, 1);
    drain();

    // R10/R11 trigger on the final checksum slot
    trig(50, 2);
    while (!(q.size() == 1 && nxt_slot)) step();
    trig(60, 4);
    chk("R11 ends after same-cycle trigger", 32'(busy_m), 0);
    repeat (8) step();

    // R5 irregular slot pattern, several frames
    slot_mode = 1;
    for (int t = 0; t < 6; t++) begin
      trig(t * 19 + 1, t * 5 + 1);
      drain();
    end
    // R12 rewrite and resend
    slot_mode = 2;
    for (int i = 0; i < 16; i++) wr(33 * 16 + i, 8'(255 - i * 3));
    trig(33, 4);
    drain();
    slot_mode = 0;
    trig(90, 500);
    drain();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule